// File: doc/BRIEF.md
# Binary Extension Field Multiply and Inverse Unit

A sequential arithmetic unit for GF(2^m). It takes two operand bytes, a field degree and the low coefficients of a reduction polynomial. A single start pulse launches the work, and the unit signals completion with a one-cycle done strobe. Two operations share one set of working registers.

The multiply walks through the second operand one bit per cycle. Each cycle it conditionally adds the multiplicand into an accumulator and then doubles the multiplicand modulo the polynomial. The degree and the polynomial are run-time inputs, so one instance serves any field of degree 1 to 8.

The inverse runs a Euclid-style reduction in the fixed 8-bit field. Its polynomial is x^8 plus the supplied low byte. Zero has no inverse and neither does an operand that shares a factor with the polynomial. For these the unit raises an error flag and returns zero, and an iteration cap stops it from looping forever.

Top module: `gfu_top`

## Requirements
- R1: While reset is held and after its release, busy, done, result and invErr are all 0.
- R2: With opSel=0 the result is a·b in GF(2^d). Both operands are first masked to their low d bits. Reduction uses polynomial x^d plus the low d bits of modLow. Each cycle does the following: if b[0] is set, XOR a into the accumulator; shift a left one place; if bit d of the shifted value is set, clear it and XOR in the low polynomial bits; shift b right one place.
- R3: A degree of 0, or any degree above 8, is treated as 8.
- R4: A multiply raises done exactly L+1 clock edges after the edge that accepted start. L is the bit length of the masked b, so the count is 1 when b is 0 and never more than d+1.
- R5: With opSel=1 the result is the inverse of a in GF(2^8) modulo x^8 + modLow, and the degree input has no effect. For example, with modLow 0x1B the operand 0x53 gives 0xCA and 1 gives 1. A successful inverse finishes within ITER_MAX+1 edges after acceptance.
- R6: An inverse of 0, or of an operand with no inverse under the given polynomial, sets invErr=1 and returns result 0. For the operand 0, done follows one edge after acceptance.
- R7: done is high for exactly one cycle and busy is low while it is high. Between completions, result and invErr do not change.
- R8: A start pulse while busy is ignored. The running operation's operands and result are unaffected, and no extra completion follows.
- R9: Every successful completion clears invErr.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Launch request, taken only when idle |
| opSel | input | 1 | 0 = multiply, 1 = inverse |
| opA | input | 8 | First operand (the value inverted for opSel=1) |
| opB | input | 8 | Second multiply operand |
| degree | input | 4 | Field degree for multiply |
| modLow | input | 8 | Polynomial coefficients below the leading term |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion strobe |
| result | output | 8 | Product or inverse, held until the next completion |
| invErr | output | 1 | Inverse had no answer |

## Verification
A multiply's result is due a data-dependent number of edges after the accepting edge: the bit length of the masked b, plus one. An inverse completes after a variable number of steps, capped at the iteration limit. The bench counts clock edges from acceptance and samples done, result and invErr on falling edges. Against that count it checks the exact multiply latency, the single-edge latency of the zero inverse, and the inverse upper bound. One cycle after each completion it samples again, to confirm that done has dropped and that the result is held.

// File: rtl/gfu_pkg.sv
package gfu_pkg;
  typedef enum logic {
    OP_MUL = 1'b0,
    OP_INV = 1'b1
  } gfOp_e;

  typedef struct packed {
    logic load;
    logic stepMul;
    logic stepInv;
    logic finishOk;
    logic finishErr;
  } gfStrobe_t;
endpackage

// File: rtl/gfu_ctrl.sv
module gfu_ctrl
  import gfu_pkg::*;
#(
  parameter int ITER_MAX = 32
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      start,
  input  gfOp_e     opSel,
  input  logic      mulEmpty,
  input  logic      invUnit,
  input  logic      invZero,
  output gfStrobe_t strobe,
  output logic      busy,
  output logic      done
);
  localparam int CW = $clog2(ITER_MAX + 1);

  typedef enum logic {ST_IDLE, ST_RUN} state_e;
  state_e         state;
  gfOp_e          opReg;
  logic [CW-1:0]  iterCnt;

  always_comb begin
    strobe = '0;
    unique case (state)
      ST_IDLE: strobe.load = start;
      ST_RUN: begin
        if (opReg == OP_MUL) begin
          if (mulEmpty) strobe.finishOk = 1'b1;
          else          strobe.stepMul  = 1'b1;
        end else begin
          if (invUnit)                                   strobe.finishOk  = 1'b1;
          else if (invZero || iterCnt == CW'(ITER_MAX))  strobe.finishErr = 1'b1;
          else                                           strobe.stepInv   = 1'b1;
        end
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      opReg   <= OP_MUL;
      iterCnt <= '0;
      done    <= 1'b0;
    end else begin
      done <= strobe.finishOk | strobe.finishErr;
      if (strobe.load) begin
        state   <= ST_RUN;
        opReg   <= opSel;
        iterCnt <= '0;
      end else if (strobe.finishOk || strobe.finishErr) begin
        state <= ST_IDLE;
      end
      if (strobe.stepInv) iterCnt <= iterCnt + 1'b1;
    end
  end

  assign busy = (state == ST_RUN);

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done); // R7
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy && $past(busy)); // R7
  AST_ITER_LIMIT: assert property (@(posedge clk) disable iff (!rstN)
    iterCnt <= CW'(ITER_MAX)); // R6
  AST_OP_STABLE: assert property (@(posedge clk) disable iff (!rstN)
    busy && $past(busy) |-> opReg == $past(opReg)); // R8
endmodule

// File: rtl/gfu_dp.sv
module gfu_dp
  import gfu_pkg::*;
#(
  parameter int W = 8
) (
  input  logic           clk,
  input  logic           rstN,
  input  gfStrobe_t      strobe,
  input  gfOp_e          opSel,
  input  logic [W-1:0]   opA,
  input  logic [W-1:0]   opB,
  input  logic [DW-1:0]  degree,
  input  logic [W-1:0]   modLow,
  output logic           mulEmpty,
  output logic           invUnit,
  output logic           invZero,
  output logic [W-1:0]   result,
  output logic           invErr
);
  localparam int DW = $clog2(W + 1);
  localparam int IW = $clog2(W);
  localparam int JW = $clog2(W + 1) + 1;

  // regX: multiplicand / a ; regY: multiplier / v ; regP: accumulator / g1
  logic [W-1:0]         regX, regY, regP, regQ, polyReg, maskReg;
  logic [DW-1:0]        degReg;
  logic signed [JW-1:0] jReg;

  function automatic logic [IW-1:0] topBit(input logic [W-1:0] x);
    topBit = '0;
    for (int i = 0; i < W; i++) if (x[i]) topBit = IW'(i);
  endfunction

  // load-time values
  logic [DW-1:0]        degEff;
  logic [W:0]           maskWide;
  logic signed [JW-1:0] jInit;
  always_comb begin
    degEff   = (degree == '0 || degree > DW'(W)) ? DW'(W) : degree;
    maskWide = ((W + 1)'(1) << degEff) - (W + 1)'(1);
    jInit    = $signed(JW'(topBit(opA))) - $signed(JW'(W));
  end

  // multiply step
  logic [W:0]   shifted;
  logic         ovf;
  logic [W-1:0] mulNextX;
  always_comb begin
    shifted  = {regX, 1'b0};
    ovf      = shifted[degReg];
    mulNextX = (shifted[W-1:0] & maskReg) ^ (ovf ? polyReg : '0);
  end

  // inverse step
  logic                 jNeg;
  logic [JW-1:0]        jAbs;
  logic [W-1:0]         xA, xV, xG1, xG2, newA, newG1;
  logic signed [JW-1:0] jNext;
  always_comb begin
    jNeg  = jReg < 0;
    jAbs  = jNeg ? JW'(-jReg) : JW'(jReg);
    xA    = jNeg ? regY : regX;
    xV    = jNeg ? regX : regY;
    xG1   = jNeg ? regQ : regP;
    xG2   = jNeg ? regP : regQ;
    newA  = xA ^ (xV << jAbs);
    newG1 = xG1 ^ (xG2 << jAbs);
    jNext = $signed(JW'(topBit(newA))) - $signed(JW'(topBit(xV)));
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      regX <= '0; regY <= '0; regP <= '0; regQ <= '0;
      polyReg <= '0; maskReg <= '0; degReg <= '0; jReg <= '0;
      result <= '0; invErr <= 1'b0;
    end else begin
      if (strobe.load) begin
        if (opSel == OP_MUL) begin
          regX    <= opA & maskWide[W-1:0];
          regY    <= opB & maskWide[W-1:0];
          regP    <= '0;
          polyReg <= modLow & maskWide[W-1:0];
          maskReg <= maskWide[W-1:0];
          degReg  <= degEff;
        end else begin
          regX    <= opA;
          regY    <= modLow;
          regP    <= W'(1);
          regQ    <= '0;
          jReg    <= jInit;
        end
      end
      if (strobe.stepMul) begin
        if (regY[0]) regP <= regP ^ regX;
        regX <= mulNextX;
        regY <= regY >> 1;
      end
      if (strobe.stepInv) begin
        regX <= newA;
        regY <= xV;
        regP <= newG1;
        regQ <= xG2;
        jReg <= jNext;
      end
      if (strobe.finishOk || strobe.finishErr) begin
        result <= strobe.finishOk ? regP : '0;
        invErr <= strobe.finishErr;
      end
    end
  end

  assign mulEmpty = (regY == '0);
  assign invUnit  = (regX == W'(1));
  assign invZero  = (regX == '0);

  AST_MUL_IN_FIELD: assert property (@(posedge clk) disable iff (!rstN)
    strobe.stepMul |=> (regX & ~maskReg) == '0); // R2
  AST_STEP_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    !(strobe.stepMul && strobe.stepInv)); // R8
  AST_J_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    strobe.stepInv |=> jReg >= -$signed(JW'(W)) && jReg < $signed(JW'(W))); // R5
endmodule

// File: rtl/gfu_top.sv
module gfu_top
  import gfu_pkg::*;
#(
  parameter int W        = 8,
  parameter int ITER_MAX = 32,
  parameter int DW       = $clog2(W + 1)
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          start,
  input  logic          opSel,
  input  logic [W-1:0]  opA,
  input  logic [W-1:0]  opB,
  input  logic [DW-1:0] degree,
  input  logic [W-1:0]  modLow,
  output logic          busy,
  output logic          done,
  output logic [W-1:0]  result,
  output logic          invErr
);
  gfStrobe_t strobe;
  logic      mulEmpty, invUnit, invZero;

  gfu_ctrl #(.ITER_MAX(ITER_MAX)) i_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .opSel(gfOp_e'(opSel)),
    .mulEmpty(mulEmpty), .invUnit(invUnit), .invZero(invZero),
    .strobe(strobe), .busy(busy), .done(done)
  );

  gfu_dp #(.W(W)) i_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .opSel(gfOp_e'(opSel)),
    .opA(opA), .opB(opB), .degree(degree), .modLow(modLow),
    .mulEmpty(mulEmpty), .invUnit(invUnit), .invZero(invZero),
    .result(result), .invErr(invErr)
  );

  AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !done |-> $stable(result) && $stable(invErr)); // R7
  AST_ERR_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    invErr |-> result == '0); // R6
endmodule

// File: tb/test_gfu_top.sv
module test_gfu_top;
  localparam int ITER_MAX = 32;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       start = 1'b0;
  logic       opSel = 1'b0;
  logic [7:0] opA = '0, opB = '0, modLow = '0;
  logic [3:0] degree = '0;
  logic       busy, done, invErr;
  logic [7:0] result;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  gfu_top #(.W(8), .ITER_MAX(ITER_MAX)) i_gfu_top (
    .clk(clk), .rstN(rstN), .start(start), .opSel(opSel), .opA(opA), .opB(opB),
    .degree(degree), .modLow(modLow), .busy(busy), .done(done),
    .result(result), .invErr(invErr)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  function automatic int effDeg(input int d);
    return (d == 0 || d > 8) ? 8 : d;
  endfunction

  function automatic logic [7:0] refMul(input logic [7:0] a, input logic [7:0] b,
                                         input int d, input logic [7:0] m);
    logic [8:0] mask, x, y, acc, poly;
    int dd;
    dd   = effDeg(d);
    mask = (9'd1 << dd) - 9'd1;
    x    = {1'b0, a} & mask;
    y    = {1'b0, b} & mask;
    poly = {1'b0, m} & mask;
    acc  = '0;
    for (int i = 0; i < 8; i++) begin
      if (y[0]) acc = acc ^ x;
      x = x << 1;
      if (x[dd]) x = (x & mask) ^ poly;
      y = y >> 1;
    end
    return acc[7:0];
  endfunction

  function automatic int bitLen(input logic [7:0] v);
    int n = 0;
    for (int i = 0; i < 8; i++) if (v[i]) n = i + 1;
    return n;
  endfunction

  function automatic logic [7:0] refInv(input logic [7:0] a, input logic [7:0] m);
    for (int x = 1; x < 256; x++)
      if (refMul(a, 8'(x), 8, m) == 8'd1) return 8'(x);
    return 8'd0;
  endfunction

  // pokeAt > 0: raise start with junk operands on that edge count while busy
  task automatic runOp(input logic op, input logic [7:0] a, input logic [7:0] b,
                       input logic [3:0] d, input logic [7:0] m, input int pokeAt,
                       output logic [7:0] res, output logic err, output int lat);
    @(negedge clk);
    opSel = op; opA = a; opB = b; degree = d; modLow = m; start = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    lat = 0;
    while (!done && lat < 200) begin
      if (pokeAt > 0 && lat == pokeAt) begin
        start = 1'b1; opA = ~a; opB = ~b; opSel = ~op;
      end else begin
        start = 1'b0;
      end
      @(posedge clk);
      lat++;
      @(negedge clk);
    end
    start = 1'b0;
    res = result;
    err = invErr;
    if (lat >= 200) check(1'b0, "R7 done never rose", lat, 0);
  endtask

  initial begin
    #1ms;
    errors++;
    checks++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [7:0] res, res2, a, b, m, e;
    logic       err;
    int         lat, d;

    void'($urandom(32'd20240611));

    // R1: reset state
    repeat (3) @(negedge clk);
    check(!busy && !done && result == 0 && !invErr, "R1 reset outputs", {busy, done, invErr, result}, 0);
    rstN = 1'b1;
    @(negedge clk);
    check(!busy && !done && result == 0 && !invErr, "R1 after release", {busy, done, invErr, result}, 0);

    // R2/R4 directed: degree 3, modulus x^3+x+1
    runOp(1'b0, 8'b111, 8'b101, 4'd3, 8'b1011, 0, res, err, lat);
    check(res == 8'b110, "R2 deg3 product", res, 8'b110);
    check(lat == 4, "R4 deg3 latency", lat, 4);

    // R7: pulse ends and result held
    @(negedge clk);
    check(!done && !busy, "R7 done one cycle", done, 0);
    check(result == 8'b110, "R7 result held", result, 8'b110);

    // R4: b = 0 completes on first edge
    runOp(1'b0, 8'h5A, 8'h00, 4'd8, 8'h1B, 0, res, err, lat);
    check(res == 0 && lat == 1, "R4 zero multiplier", {res, 8'(lat)}, 1);

    // R3: degree 0 and 12 act as 8
    runOp(1'b0, 8'h80, 8'h83, 4'd0, 8'h1B, 0, res, err, lat);
    e = refMul(8'h80, 8'h83, 8, 8'h1B);
    check(res == e, "R3 degree 0 as 8", res, e);
    runOp(1'b0, 8'h80, 8'h83, 4'd12, 8'h1B, 0, res2, err, lat);
    check(res2 == e, "R3 degree 12 as 8", res2, e);
    check(lat == 9, "R4 full width latency", lat, 9);

    // R5: known inverse pair and inverse of one, degree input ignored
    runOp(1'b1, 8'h53, 8'h00, 4'd3, 8'h1B, 0, res, err, lat);
    check(res == 8'hCA && !err, "R5 inverse of 0x53", res, 8'hCA);
    check(lat <= ITER_MAX + 1, "R5 inverse bound", lat, ITER_MAX + 1);
    runOp(1'b1, 8'h01, 8'h00, 4'd8, 8'h1B, 0, res, err, lat);
    check(res == 8'h01 && lat == 1, "R5 inverse of one", {res, 8'(lat)}, 16'h0101);

    // R6: zero, then non-invertible under x^8+1
    runOp(1'b1, 8'h00, 8'h00, 4'd8, 8'h1B, 0, res, err, lat);
    check(err && res == 0, "R6 zero inverse flag", {err, res}, 9'h100);
    check(lat == 1, "R6 zero inverse latency", lat, 1);
    runOp(1'b1, 8'h03, 8'h00, 4'd8, 8'h01, 0, res, err, lat);
    check(err && res == 0, "R6 non-invertible", {err, res}, 9'h100);
    check(lat <= ITER_MAX + 1, "R6 bounded", lat, ITER_MAX + 1);

    // R9: success clears the flag
    runOp(1'b0, 8'h02, 8'h03, 4'd4, 8'h03, 0, res, err, lat);
    e = refMul(8'h02, 8'h03, 4, 8'h03);
    check(!err && res == e, "R9 error cleared", {err, res}, e);

    // R8: start during busy is ignored
    runOp(1'b0, 8'hB7, 8'hF1, 4'd8, 8'h1D, 2, res, err, lat);
    e = refMul(8'hB7, 8'hF1, 8, 8'h1D);
    check(res == e, "R8 busy start ignored result", res, e);
    check(lat == 9, "R8 busy start ignored latency", lat, 9);
    repeat (3) @(negedge clk);
    check(!busy && !done && result == e, "R8 no extra run", {busy, done}, 0);

    // R2/R4 random multiplies
    for (int n = 0; n < 80; n++) begin
      d = 1 + ($urandom % 8);
      a = 8'($urandom); b = 8'($urandom); m = 8'($urandom);
      runOp(1'b0, a, b, 4'(d), m, 0, res, err, lat);
      e = refMul(a, b, d, m);
      check(res == e && !err, "R2 random product", res, e);
      check(lat == bitLen(b & 8'((9'd1 << d) - 9'd1)) + 1, "R4 random latency", lat,
            bitLen(b & 8'((9'd1 << d) - 9'd1)) + 1);
    end

    // R5 random inverses under two irreducible polynomials
    for (int n = 0; n < 40; n++) begin
      a = 8'(1 + ($urandom % 255));
      m = n[0] ? 8'h1D : 8'h1B;
      runOp(1'b1, a, 8'($urandom), 4'($urandom), m, 0, res, err, lat);
      e = refInv(a, m);
      check(res == e && !err, "R5 random inverse", res, e);
      check(lat <= ITER_MAX + 1, "R5 random bound", lat, ITER_MAX + 1);
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule